// File: doc/BRIEF.md
# PWM Channel with Cascaded Clock Dividers

This block is a single pulse-width-modulated output channel. A control word chooses one of two source clock enables, a fast one or a slow one. Both arrive as single-cycle strobes on the one system clock. The chosen strobe passes through a power-of-two divider and then through a linear divide-by-(k+1) prescaler. Each strobe that leaves the prescaler is one tick of the channel. A 16-bit counter counts ticks through a programmable period. A compare against an active-cycle count decides, tick by tick, whether the output sits at its active or its inactive level.

Software programs the channel over a small word-wide register bus with readback. The bus has an address, a write enable and write data, and read data is combinational. Period and active-cycle values go into shadow registers. The counter takes them over only when a period ends, or at once while the channel is stopped, so a change never cuts a period short. A polarity bit selects which level counts as active. A bypass bit sends the selected source strobe straight to the pin. The channel runs only while both its gate bit and its enable bit are set. The block has no streaming data path, so it has no valid/ready handshake: every pin is plain control or register access.

Top module: `pwm_divchan`

## Requirements
- R1: Control bit 4 selects the tick source: 1 uses `fast_stb`, 0 uses `slow_stb`.
- R2: Control bits 11:8 hold a divider code n. The selected strobe is divided by 2^n for n from 0 to 8, and codes 9 to 15 divide by 256, the same as code 8.
- R3: Control bits 23:16 hold a prescale value k. The power-of-two output is further divided by k+1.
- R4: Register address 1, bits 15:0, holds the number of ticks per PWM period minus one.
- R5: Register address 2, bits 15:0, holds the number of ticks at the start of each period during which the output is at its active level. For the rest of the period the output is at its inactive level.
- R6: Control bit 2 sets polarity. 1 makes the active level high and 0 makes it low. The bit resets to 1.
- R7: While the channel runs with control bit 3 (bypass) set, `pwm_out` equals the selected source strobe, whatever the divider, prescale, period and active settings are.
- R8: The channel runs only when control bit 1 (gate) and control bit 0 (enable) are both 1. Otherwise the tick counter is held at zero and `pwm_out` stays at the inactive level.
- R9: An active count of 0 gives 0% duty. An active count at or above the period count (field + 1) gives 100% duty.
- R10: A write to the period or active register while the channel runs takes effect only from the next period boundary. While the channel is stopped, the values take effect as soon as it starts.
- R11: Readback returns the stored control, period and active values. Reserved bits read 0, and address 3 reads 0. After reset the control word reads 0x00000004 and the period and active registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_stb | input | 1 | Fast source clock enable strobe |
| slow_stb | input | 1 | Slow source clock enable strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions check these rules on every cycle:
- a tick is produced only on a selected source strobe;
- the tick counter never passes the working period;
- the counter is held at zero and the output sits at the inactive level whenever gate or enable is low;
- bypass copies the strobe to the pin;
- the working active count changes during a run only at a period wrap;
- reserved control bits read zero.

Only the bench scenarios can show the quantities that build up over many cycles. These are the actual divide ratios through both divider stages, the number of active cycles and rising edges in a whole number of periods for each polarity, and the 0% and 100% duty limits. The scenarios also show that a mid-period write to the active count leaves the current period unchanged and shapes the next one.

// File: rtl/pwm_divchan_pkg.sv
package pwm_divchan_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int PER_W   = 16;
  localparam int PRE_W   = 8;
  localparam int DIVC_W  = 4;
  localparam int DIV_MAX = 8;

  // control word bit positions
  localparam int B_RUN   = 0;
  localparam int B_GATE  = 1;
  localparam int B_POL   = 2;
  localparam int B_BYP   = 3;
  localparam int B_SRC   = 4;
  localparam int B_DIVC  = 8;
  localparam int B_PRE   = 16;

  localparam logic [DATA_W-1:0] CTRL_MASK =
      (DATA_W'((1 << PRE_W) - 1) << B_PRE) |
      (DATA_W'((1 << DIVC_W) - 1) << B_DIVC) |
      DATA_W'(32'h1F);
  localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'(1) << B_POL;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 2'd0,
    A_PERIOD = 2'd1,
    A_ACTIVE = 2'd2,
    A_NONE   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [PRE_W-1:0]  presc;
    logic [DIVC_W-1:0] divc;
    logic              src_fast;
    logic              bypass;
    logic              act_high;
    logic              gate_on;
    logic              run_en;
  } ctrl_t;
endpackage

// File: rtl/pwm_divchan_regs.sv
module pwm_divchan_regs
  import pwm_divchan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic [PER_W-1:0]  per_sh,
  output logic [PER_W-1:0]  act_sh
);
  logic [DATA_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      per_sh <= '0;
      act_sh <= '0;
    end else if (we) begin
      case (reg_addr_e'(addr))
        A_CTRL:   ctrl_q <= wdata & CTRL_MASK;
        A_PERIOD: per_sh <= wdata[PER_W-1:0];
        A_ACTIVE: act_sh <= wdata[PER_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    ctrl.run_en   = ctrl_q[B_RUN];
    ctrl.gate_on  = ctrl_q[B_GATE];
    ctrl.act_high = ctrl_q[B_POL];
    ctrl.bypass   = ctrl_q[B_BYP];
    ctrl.src_fast = ctrl_q[B_SRC];
    ctrl.divc     = ctrl_q[B_DIVC +: DIVC_W];
    ctrl.presc    = ctrl_q[B_PRE +: PRE_W];
  end

  always_comb begin
    case (reg_addr_e'(addr))
      A_CTRL:   rdata = ctrl_q;
      A_PERIOD: rdata = DATA_W'(per_sh);
      A_ACTIVE: rdata = DATA_W'(act_sh);
      default:  rdata = '0;
    endcase
  end

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTRL) |-> ((rdata & ~CTRL_MASK) == '0)); // R11
endmodule

// File: rtl/pwm_divchan_clkdiv.sv
module pwm_divchan_clkdiv
  import pwm_divchan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              fast_stb,
  input  logic              slow_stb,
  input  logic              src_fast,
  input  logic [DIVC_W-1:0] divc,
  input  logic [PRE_W-1:0]  presc,
  output logic              sel_stb,
  output logic              tick
);
  localparam logic [DIVC_W-1:0] N_MAX = DIVC_W'(DIV_MAX);

  logic [DIV_MAX-1:0] p_q;
  logic [DIV_MAX-1:0] mask;
  logic [PRE_W-1:0]   q_q;
  logic [DIVC_W-1:0]  eff_n;
  logic               d2;

  assign sel_stb = src_fast ? fast_stb : slow_stb;
  assign eff_n   = (divc > N_MAX) ? N_MAX : divc;

  for (genvar i = 0; i < DIV_MAX; i++) begin : g_mask
    assign mask[i] = (DIVC_W'(i) < eff_n);
  end

  assign d2   = sel_stb && ((p_q & mask) == mask);
  assign tick = d2 && (q_q >= presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
      q_q <= '0;
    end else if (!run) begin
      p_q <= '0;
      q_q <= '0;
    end else begin
      if (sel_stb) p_q <= p_q + 1'b1;
      if (d2)      q_q <= (q_q >= presc) ? '0 : q_q + 1'b1;
    end
  end

  AST_TICK_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> sel_stb); // R2
  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (p_q == '0 && q_q == '0)); // R8
endmodule

// File: rtl/pwm_divchan_period.sv
module pwm_divchan_period
  import pwm_divchan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [PER_W-1:0] per_sh,
  input  logic [PER_W-1:0] act_sh,
  output logic             in_active
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] per_w;
  logic [PER_W-1:0] act_w;
  logic             wrap;

  assign wrap      = tick && (cnt_q >= per_w);
  assign in_active = (cnt_q < act_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_w <= '0;
      act_w <= '0;
    end else if (!run) begin
      cnt_q <= '0;
      per_w <= per_sh;
      act_w <= act_sh;
    end else if (tick) begin
      if (wrap) begin
        cnt_q <= '0;
        per_w <= per_sh;
        act_w <= act_sh;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_w); // R4
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R8
  AST_SHADOW_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(act_w)) |-> $past(wrap)); // R10
endmodule

// File: rtl/pwm_divchan.sv
module pwm_divchan
  import pwm_divchan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_stb,
  input  logic              slow_stb,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out
);
  ctrl_t            ctrl;
  logic [PER_W-1:0] per_sh;
  logic [PER_W-1:0] act_sh;
  logic             run;
  logic             sel_stb;
  logic             tick;
  logic             in_active;

  pwm_divchan_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .ctrl   (ctrl),
    .per_sh (per_sh),
    .act_sh (act_sh)
  );

  assign run = ctrl.run_en && ctrl.gate_on;

  pwm_divchan_clkdiv u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .fast_stb (fast_stb),
    .slow_stb (slow_stb),
    .src_fast (ctrl.src_fast),
    .divc     (ctrl.divc),
    .presc    (ctrl.presc),
    .sel_stb  (sel_stb),
    .tick     (tick)
  );

  pwm_divchan_period u_per (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .per_sh    (per_sh),
    .act_sh    (act_sh),
    .in_active (in_active)
  );

  always_comb begin
    if (!run)             pwm_out = !ctrl.act_high;
    else if (ctrl.bypass) pwm_out = sel_stb;
    else                  pwm_out = in_active ? ctrl.act_high : !ctrl.act_high;
  end

  AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl.run_en && ctrl.gate_on) |-> (pwm_out == !ctrl.act_high)); // R8
  AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctrl.bypass) |-> (pwm_out == (ctrl.src_fast ? fast_stb : slow_stb))); // R7
endmodule

// File: tb/pwm_divchan_test.sv
module pwm_divchan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fast_stb = 1'b0;
  logic        slow_stb = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwm_out;

  int n_tests = 0;
  int n_fail  = 0;
  int stb_cnt = 0;
  bit done    = 1'b0;

  pwm_divchan uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_stb  (fast_stb),
    .slow_stb  (slow_stb),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out)
  );

  always #5 clk = ~clk;

  // fast strobe every 2nd cycle, slow strobe every 5th cycle
  always @(negedge clk) begin
    stb_cnt  <= stb_cnt + 1;
    fast_stb <= (stb_cnt % 2 == 0);
    slow_stb <= (stb_cnt % 5 == 0);
  end

  typedef struct packed {
    logic        src;
    logic [3:0]  n;
    logic [7:0]  k;
    logic [15:0] per;
    logic [15:0] act;
    logic        pol;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd0,  8'd0, 16'd9, 16'd3, 1'b1},   // R1 R4 R5 fast, plain
    '{1'b0, 4'd1,  8'd2, 16'd4, 16'd2, 1'b1},   // R1 R2 R3 slow
    '{1'b1, 4'd3,  8'd0, 16'd3, 16'd0, 1'b1},   // R9 0% duty
    '{1'b1, 4'd0,  8'd1, 16'd5, 16'd6, 1'b1},   // R9 100% duty
    '{1'b1, 4'd2,  8'd1, 16'd7, 16'd5, 1'b0},   // R6 low active
    '{1'b0, 4'd8,  8'd0, 16'd1, 16'd1, 1'b1},   // R2 code 8
    '{1'b0, 4'd12, 8'd0, 16'd1, 16'd1, 1'b1}    // R2 code 12 acts as 8
  };

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] mk(input bit run, input bit gate, input bit pol,
                                     input bit byp, input bit src,
                                     input logic [3:0] n, input logic [7:0] k);
    return {8'd0, k, 4'd0, n, 3'd0, src, byp, pol, gate, run};
  endfunction

  task automatic measure(input int cyc, output int highs, output int rises);
    logic prev;
    highs = 0; rises = 0;
    @(negedge clk); #1 prev = pwm_out;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk); #1;
      if (pwm_out) highs++;
      if (pwm_out && !prev) rises++;
      prev = pwm_out;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int h, r, t, p, a, q, expw;
    logic prev;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state (R11, R6, R8)
    rd(2'd0, d); check("R11 ctrl reset", int'(d), 4);
    rd(2'd1, d); check("R11 period reset", int'(d), 0);
    rd(2'd2, d); check("R11 active reset", int'(d), 0);
    #1 check("R8 output inactive after reset", int'(pwm_out), 0);

    // reserved bits (R11)
    wr(2'd0, 32'hFFFF_FFE0);
    rd(2'd0, d); check("R11 reserved ctrl bits", int'(d), 32'h00FF_0F00);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d); check("R11 addr3 reads zero", int'(d), 0);
    wr(2'd1, 32'hABCD_1234);
    rd(2'd1, d); check("R11 period readback", int'(d), 32'h1234);

    // vector table
    for (int v = 0; v < NV; v++) begin
      wr(2'd0, mk(0, 0, VECS[v].pol, 0, 0, 0, 0));
      wr(2'd1, {16'd0, VECS[v].per});
      wr(2'd2, {16'd0, VECS[v].act});
      wr(2'd0, mk(1, 1, VECS[v].pol, 0, VECS[v].src, VECS[v].n, VECS[v].k));
      q = (VECS[v].n > 8) ? 8 : int'(VECS[v].n);
      t = (VECS[v].src ? 2 : 5) * (1 << q) * (int'(VECS[v].k) + 1);
      p = t * (int'(VECS[v].per) + 1);
      a = (int'(VECS[v].act) > int'(VECS[v].per)) ? p : t * int'(VECS[v].act);
      repeat (2 * p) @(negedge clk);
      measure(4 * p, h, r);
      expw = VECS[v].pol ? a : p - a;
      check($sformatf("R1 R2 R3 R5 R6 R9 vec%0d active cycles", v), h, 4 * expw);
      check($sformatf("R4 R9 vec%0d rises", v), r,
            (a == 0 || a == p) ? 0 : 4);
    end

    // gate without enable, enable without gate (R8)
    wr(2'd0, mk(0, 1, 1, 0, 1, 0, 0));
    wr(2'd1, 32'd3); wr(2'd2, 32'd2);
    measure(40, h, r); check("R8 gate only stays inactive", h, 0);
    wr(2'd0, mk(1, 0, 0, 0, 1, 0, 0));
    measure(40, h, r); check("R8 enable only stays inactive (low pol)", h, 40);

    // bypass (R7)
    wr(2'd0, mk(1, 1, 0, 1, 1, 3, 5));
    measure(20, h, r); check("R7 bypass fast", h, 10);
    wr(2'd0, mk(1, 1, 1, 1, 0, 3, 5));
    measure(20, h, r); check("R7 bypass slow", h, 4);

    // shadow update at period end (R10)
    wr(2'd0, mk(0, 0, 1, 0, 0, 0, 0));
    wr(2'd1, 32'd9); wr(2'd2, 32'd3);
    wr(2'd0, mk(1, 1, 1, 0, 1, 0, 0));
    repeat (60) @(negedge clk);
    #1 prev = pwm_out;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (pwm_out && !prev) break;
      prev = pwm_out;
    end
    h = 1;
    prev = 1'b1;
    for (int i = 1; i < 100; i++) begin
      @(negedge clk);
      if (i == 8) begin reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'd7; end
      else reg_we = 1'b0;
      #1;
      if (pwm_out && !prev) break;
      if (pwm_out) h++;
      prev = pwm_out;
    end
    check("R10 current period keeps old active count", h, 6);
    h = 1;
    prev = 1'b1;
    for (int i = 1; i < 100; i++) begin
      @(negedge clk); #1;
      if (pwm_out && !prev) break;
      if (pwm_out) h++;
      prev = pwm_out;
    end
    check("R10 next period uses new active count", h, 14);

    // stop mid-run (R8)
    wr(2'd0, mk(0, 1, 1, 0, 1, 0, 0));
    measure(30, h, r); check("R8 stopped channel inactive", h, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule